// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits each and returns their full `2W`-bit product. It spends one clock cycle per multiplier bit and uses a single `W`-bit adder. A pulse on `start` while the unit is idle captures both operands. The multiplicand is copied into a fixed `W`-bit register. The multiplier is copied into the lower half of one `2W`-bit working register, whose upper half starts at zero.

Each step looks at the lowest bit of the working register. When that bit is set, the multiplicand is added into the upper half. The whole register then moves one place right, and the adder's carry enters at the top. The multiplier bits leave at the bottom as the product bits come in at the top. After `W` steps the register holds the product. `done` is then raised for exactly one cycle and the unit goes back to idle.

The working register drives `product` directly, so the partial results can be seen while the unit runs.

Top module: `seq_mult`

## Requirements
- R1: A `start` sampled high while `busy` is low captures the operands. On the next cycle `busy` is 1 and `product` equals `{W zeros, mplier}`.
- R2: The multiplicand is taken only at that capture. Changes on `mcand` or `mplier` during an operation do not alter its result.
- R3: Each step adds the captured multiplicand into the upper half when bit 0 of `product` is 1, and adds nothing when it is 0. The full `2W` bits then shift right by one. With W=4, multiplicand 3 and multiplier 5, `product` reads 0x1A, 0x0D, 0x1E, 0x0F after steps 1 to 4.
- R4: The carry out of the `W`-bit add enters bit `2W-1` on the shift. If there is no carry, a 0 enters there. With W=4, 15 times 15 gives 0xE1.
- R5: `done` is high in the cycle that follows the W-th rising edge after the edge that captured `start`.
- R6: When `done` is high, `product` equals the unsigned product of the captured operands.
- R7: `done` stays high for exactly one cycle. After that cycle `busy` and `done` are both 0.
- R8: A `start` that arrives while `busy` is 1 is ignored. This covers every step cycle and the `done` cycle.
- R9: While `rst_n` is low, `product`, `busy` and `done` are all 0, including when reset lands in the middle of an operation.
- R10: While the unit is idle and `start` is low, `product` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; acted on only when idle |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | High from capture through the `done` cycle |
| done | output | 1 | One-cycle flag: the product is complete |
| product | output | 2W | Working register: partial result while running, final product once done |

## Verification
The functions that can meet in one cycle are a new `start` request and an operation that is still running or finishing. The case that matters most is the cycle in which `done` is high. In some sweeps the bench holds `start` high from the capture until one cycle past `done`, and keeps changing both operand inputs on every cycle. It judges that the result still matches the first operands, that `done` comes at the normal cycle, and that the unit ends up idle without starting a second operation.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t         state;
  logic [W-1:0]   mc_q;
  logic [2*W-1:0] acc;
  logic [CW-1:0]  step;
  logic [W:0]     sum;

  assign sum     = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mc_q} : '0);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign product = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      mc_q  <= '0;
      acc   <= '0;
      step  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          acc   <= {{W{1'b0}}, mplier};
          mc_q  <= mcand;
          step  <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          acc  <= {sum, acc[W-1:1]};
          step <= step + 1'b1;
          if (step == CW'(W - 1)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module seq_mult_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int KW = $clog2(W + 2) + 1;

  logic [KW-1:0]  edges;
  logic [2*W-1:0] expect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges    <= '0;
      expect_q <= '0;
    end else if (!busy && start) begin
      edges    <= '0;
      expect_q <= {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
    end else if (busy) begin
      edges <= edges + 1'b1;
    end
  end

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && product == {{W{1'b0}}, $past(mplier)})); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edges == KW'(W))); // R5
  AST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == expect_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R7
  AST_START_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R10
endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_seq_mult.sv
module tb_seq_mult;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seq_mult #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy);
    logic [2*W-1:0] exp_p;
    int lat;
    exp_p = (2*W)'(a) * (2*W)'(b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    if (!noisy) start = 1'b0;
    chk(busy && product == {{W{1'b0}}, b}, "R1 load", longint'(product), longint'(b));
    lat = 1;
    while (!done && lat < 40) begin
      if (noisy) begin mcand = ~mcand; mplier = mplier + 1'b1; end
      @(negedge clk);
      lat++;
    end
    chk(lat == W + 1, "R5 latency", lat, W + 1);
    chk(product == exp_p, noisy ? "R2 R8 R6 product under noise" : "R6 product",
        longint'(product), longint'(exp_p));
    @(negedge clk);
    chk(!done && !busy, "R7 R8 idle after done", {busy, done}, 0);
    chk(product == exp_p, "R10 hold after done", longint'(product), longint'(exp_p));
    start = 1'b0;
  endtask

  initial begin
    logic [2*W-1:0] trace [4];
    trace[0] = 8'h1A; trace[1] = 8'h0D; trace[2] = 8'h1E; trace[3] = 8'h0F;

    repeat (3) @(negedge clk);
    chk(product == '0 && !busy && !done, "R9 reset state", longint'({busy, done, product}), 0);
    rst_n = 1'b1;

    // R3 step trace for 3 x 5
    @(negedge clk);
    mcand = 4'd3; mplier = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(product == trace[i], "R3 step trace", longint'(product), longint'(trace[i]));
    end
    chk(done, "R5 done after trace", done, 1);
    @(negedge clk);

    // R4 carry into top bit
    run_op(4'hF, 4'hF, 1'b0);
    chk(product == 8'hE1, "R4 carry 15x15", longint'(product), 8'hE1);

    // exhaustive sweep, every third pair with start held and inputs churning
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(W'(a), W'(b), ((a + b) % 3) == 0);

    // R10 idle hold with operand churn
    begin
      logic [2*W-1:0] held;
      held = product;
      for (int i = 0; i < 5; i++) begin
        mcand = W'(i); mplier = W'(7 - i);
        @(negedge clk);
        chk(product == held && !busy, "R10 idle hold", longint'(product), longint'(held));
      end
    end

    // R9 reset in the middle of a run
    @(negedge clk);
    mcand = 4'd9; mplier = 4'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(product == '0 && !busy && !done, "R9 mid-run reset", longint'({busy, done, product}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(4'd9, 4'd7, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule